// File: doc/BRIEF.md
# Shadow Store/Recall Sequencing Controller

This block owns a small volatile working array and a nonvolatile shadow array of the same size, and moves data between them. A store request erases the shadow and then copies the working array into it. A recall request clears the working array and then fills it from the shadow. Two supply comparator flags control the power behaviour. Stores are refused while the supply sits below the upper (switch) threshold. A dip below the lower (reset) threshold arms an automatic recall, which runs as soon as the supply is back above the switch threshold. Power-on reset arms the same automatic recall.

Each transfer moves one word per clock. Every operation then holds `busy` for a fixed, parameterized number of cycles, whatever the array size. While `busy` is high, the host port is shut off. While `busy` is low, the host reads and writes the working array with single-cycle accesses. Read data appears on the clock after the request.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy` is 0 and `host_rdata` is 0. Reset arms a pending automatic recall.
- R2: With `busy` low, `host_en`=1 and `host_we`=1 write `host_wdata` into word `host_addr` at the clock edge. `host_en`=1 and `host_we`=0 load that word into `host_rdata` at the edge, so it is visible one cycle later.
- R3: While `busy` is high, host accesses have no effect: writes leave the array unchanged and `host_rdata` holds its value.
- R4: A `store_req` sampled while idle, with `supply_ok`=1 and no pending automatic recall, runs a store. The store first erases the shadow, then copies the working array into it. `busy` rises at that edge and stays high for exactly `ST_CYC` cycles.
- R5: A `recall_req` sampled while idle, with no pending automatic recall, runs a recall. The recall first clears the working array, then copies the shadow into it. `busy` is high for exactly `RC_CYC` cycles.
- R6: `supply_low`=1 at any clock edge arms a pending automatic recall. When idle with a pending recall and `supply_ok`=1, a recall starts with a `busy` time of exactly `PU_CYC` cycles, and the pending flag clears.
- R7: A supply dip with `supply_ok`=0 but `supply_low` never 1 arms nothing. When the supply recovers, `busy` stays low and the working array is unchanged.
- R8: A `store_req` sampled while `supply_ok`=0 is ignored: `busy` stays low and the shadow is unchanged.
- R9: Requests sampled while busy are dropped. A pending automatic recall takes precedence over software requests, and those requests are dropped. When both software requests arrive together, the store wins.
- R10: A recall never modifies the shadow, so repeated recalls restore the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-on) |
| supply_ok | input | 1 | Supply above switch threshold |
| supply_low | input | 1 | Supply below reset threshold |
| store_req | input | 1 | Software store request |
| recall_req | input | 1 | Software recall request |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, registered |
| busy | output | 1 | Transfer in progress, host blocked |

## Verification
A wrong sequencer state appears at the ports in one of two ways. The first is a `busy` window of the wrong length, which shows up on the very first cycle it deviates. The second is a start or refusal in the wrong cycle, which also shows up on the cycle it occurs. A corrupted array word, or a transfer phase in the wrong order, stays hidden until the host reads that word after the operation ends. A broken store only shows up after a later recall. The bench therefore follows every store with overwrites, then recalls and reads back every address.

// File: rtl/nv_shadow_ctrl.sv
module nv_shadow_ctrl #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int ST_CYC = 64,
  parameter int RC_CYC = 40,
  parameter int PU_CYC = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          supply_low,
  input  logic          store_req,
  input  logic          recall_req,
  input  logic          host_en,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int TW = $clog2(ST_CYC + RC_CYC + PU_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WIPE, S_COPY, S_HOLD} st_t;

  st_t           st;
  logic          is_store;
  logic          pf_pend;
  logic [AW-1:0] idx;
  logic [TW-1:0] tmr, dur;
  logic [DW-1:0] work   [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  wire idle     = (st == S_IDLE);
  wire go_pu    = idle & pf_pend & supply_ok;
  wire go_st    = idle & ~pf_pend & store_req & supply_ok;
  wire go_rc    = idle & ~pf_pend & ~go_st & recall_req;
  wire host_ok  = idle & host_en;
  wire last_idx = (idx == AW'(DEPTH - 1));

  assign busy = ~idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      is_store   <= 1'b0;
      pf_pend    <= 1'b1;
      idx        <= '0;
      tmr        <= '0;
      dur        <= '0;
      host_rdata <= '0;
    end else begin
      pf_pend <= (pf_pend & ~go_pu) | supply_low;
      if (host_ok && !host_we) host_rdata <= work[host_addr];
      case (st)
        S_IDLE: begin
          idx <= '0;
          tmr <= '0;
          if (go_pu || go_st || go_rc) begin
            st       <= S_WIPE;
            is_store <= go_st;
            dur      <= go_pu ? TW'(PU_CYC) : go_st ? TW'(ST_CYC) : TW'(RC_CYC);
          end
        end
        S_WIPE: begin
          tmr <= tmr + 1'b1;
          idx <= idx + 1'b1;
          if (last_idx) st <= S_COPY;
        end
        S_COPY: begin
          tmr <= tmr + 1'b1;
          idx <= idx + 1'b1;
          if (last_idx) st <= S_HOLD;
        end
        default: begin
          tmr <= tmr + 1'b1;
          if (tmr >= dur - 1'b1) st <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (host_ok && host_we) work[host_addr] <= host_wdata;
    if (st == S_WIPE) begin
      if (is_store) shadow[idx] <= '1;
      else          work[idx]   <= '0;
    end
    if (st == S_COPY) begin
      if (is_store) shadow[idx] <= work[idx];
      else          work[idx]   <= shadow[idx];
    end
  end
endmodule

// File: rtl/nv_shadow_ctrl_chk.sv
module nv_shadow_ctrl_chk #(
  parameter int DW     = 8,
  parameter int ST_CYC = 64,
  parameter int RC_CYC = 40,
  parameter int PU_CYC = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          store_req,
  input logic          recall_req,
  input logic          pf_pend,
  input logic          busy,
  input logic [DW-1:0] host_rdata
);
  logic [31:0] bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= '0;
  end

  AST_RDATA_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(host_rdata)); // R3

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == ST_CYC || bcnt == RC_CYC || bcnt == PU_CYC)); // R4

  AST_NO_AUTO_RECALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pf_pend && !supply_ok) |=> !busy); // R6

  AST_QUIET_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pf_pend && !store_req && !recall_req) |=> !busy); // R7

  AST_STORE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pf_pend && store_req && !recall_req && !supply_ok) |=> !busy); // R8
endmodule

bind nv_shadow_ctrl nv_shadow_ctrl_chk #(
  .DW(DW), .ST_CYC(ST_CYC), .RC_CYC(RC_CYC), .PU_CYC(PU_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .store_req(store_req),
  .recall_req(recall_req), .pf_pend(pf_pend), .busy(busy), .host_rdata(host_rdata)
);

// File: tb/nv_shadow_ctrl_tb_top.sv
`timescale 1ns/1ps
module nv_shadow_ctrl_tb_top;
  localparam int AW = 4, DW = 8, ST = 64, RC = 40, PU = 48;
  localparam int N = 1 << AW;

  logic clk = 0, rst_n = 0, vok = 0, vlow = 0, st_req = 0, rc_req = 0;
  logic h_en = 0, h_we = 0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wd = '0;
  logic [DW-1:0] h_rd;
  logic busy;

  nv_shadow_ctrl #(.AW(AW), .DW(DW), .ST_CYC(ST), .RC_CYC(RC), .PU_CYC(PU)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(vok), .supply_low(vlow),
    .store_req(st_req), .recall_req(rc_req), .host_en(h_en), .host_we(h_we),
    .host_addr(h_addr), .host_wdata(h_wd), .host_rdata(h_rd), .busy(busy));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R1";
  int wk[N], sh[N];
  bit wok[N], sok[N];
  int left = 0, rd = 0;
  bit pf = 1, rdok = 1;

  task automatic chk(string r, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    if (!rst_n) begin
      left = 0; pf = 1; rd = 0; rdok = 1;
    end else begin
      if (left > 0) left--;
      else begin
        if (h_en) begin
          if (h_we) begin wk[h_addr] = h_wd; wok[h_addr] = 1; end
          else begin rd = wk[h_addr]; rdok = wok[h_addr]; end
        end
        if (pf) begin
          if (vok) begin
            for (int i = 0; i < N; i++) begin wk[i] = sh[i]; wok[i] = sok[i]; end
            left = PU; pf = 0;
          end
        end else if (st_req && vok) begin
          for (int i = 0; i < N; i++) begin sh[i] = wk[i]; sok[i] = wok[i]; end
          left = ST;
        end else if (rc_req) begin
          for (int i = 0; i < N; i++) begin wk[i] = sh[i]; wok[i] = sok[i]; end
          left = RC;
        end
      end
      if (vlow) pf = 1;
    end
    chk(tag, int'(busy), int'(left > 0), "busy");
    if (rdok) chk(tag, int'(h_rd), rd, "rdata");
  endtask

  task automatic idle(int n);
    st_req = 0; rc_req = 0; h_en = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    h_en = 1; h_we = 1; h_addr = AW'(a); h_wd = DW'(d);
    step();
    h_en = 0; h_we = 0;
  endtask

  task automatic rdw(int a);
    h_en = 1; h_we = 0; h_addr = AW'(a);
    step();
    h_en = 0;
    step();
  endtask

  task automatic drain();
    int g = 0;
    while (busy && g < 1000) begin step(); g++; end
  endtask

  task automatic fill(int k);
    for (int a = 0; a < N; a++) wr(a, (a * k + 3) & 8'hff);
  endtask

  task automatic read_all();
    for (int a = 0; a < N; a++) rdw(a);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R1"; idle(3);
    rst_n = 1; idle(1);
    tag = "R9"; st_req = 1; rc_req = 1; step(); idle(3);
    tag = "R6"; vok = 1; step(); idle(2); drain(); idle(2);
    tag = "R2"; fill(17); read_all();
    tag = "R4"; st_req = 1; step(); st_req = 0; idle(2);
    tag = "R3";
    for (int a = 0; a < 10; a++) wr(a, 8'h5a);
    rdw(1); rc_req = 1; step(); rc_req = 0;
    drain(); idle(1);
    tag = "R3"; read_all();
    tag = "R5"; fill(29); read_all();
    rc_req = 1; step(); rc_req = 0; drain(); idle(1); read_all();
    tag = "R10"; fill(7);
    rc_req = 1; step(); rc_req = 0; drain(); idle(1); read_all();
    tag = "R8"; vok = 0; idle(2); fill(11);
    st_req = 1; step(); st_req = 0; idle(3);
    vok = 1; idle(2);
    rc_req = 1; step(); rc_req = 0; drain(); idle(1); read_all();
    tag = "R7"; fill(5); vok = 0; idle(5); vok = 1; idle(5); read_all();
    tag = "R6"; fill(13); vok = 0; vlow = 1; step(); vlow = 0; idle(2);
    st_req = 1; step(); rc_req = 1; step(); st_req = 0; rc_req = 0; idle(2);
    vok = 1; step(); drain(); idle(1); read_all();
    tag = "R9"; fill(19); st_req = 1; rc_req = 1; step(); st_req = 0; rc_req = 0;
    drain(); idle(1); fill(23);
    rc_req = 1; step(); rc_req = 0; drain(); idle(1); read_all();
    tag = "R1"; rst_n = 0; idle(2); rst_n = 1; step(); drain(); idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule